// File: doc/BRIEF.md
# Periodic Sequencer Start Controller

This block decides when a timing state machine begins a new sequence. It runs on the slow reference clock that also steps the sequencer. It gives one start pulse per sequence and never starts a second sequence while one is still running.

It has two modes. In periodic mode a programmable divider sets the start period. The period is the product of a second-stage factor and two third-stage fields, counted in reference cycles. In repeat mode the divider is bypassed. A new sequence begins on the reference cycle right after the running sequence reaches its last state.

Divider writes land in a shadow copy and take effect only at the next sequence start. Two sticky flags record sequence starts and stop-state arrivals, so software can measure the gap between them. Each flag is cleared by writing 1.

Top module: `seq_start_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `seq_start`, `start_flag` and `stop_flag` are 0. The shadow and active divider settings take the reset defaults div2=2, div3a=9 and div3b=18, which gives a period of 324.
- R2: When the block leaves reset it is idle and its period has already expired. `seq_start` is therefore 1 in the cycle after the first clock edge that samples `rst` low.
- R3: With `repeat_mode`=0, the start period P is `div2*div3a*div3b` reference cycles. If each sequence stops within P cycles, consecutive `seq_start` pulses are exactly P cycles apart.
- R4: A write through `cfg_wr` changes only the shadow settings. The interval already counting runs to the end with the old period. The new period applies from the next start onward.
- R5: A divide product of 0 or 1 gives a period of 1 cycle. `seq_start` may then be 1 in every cycle.
- R6: A sequence runs from its `seq_start` cycle until a cycle in which `seq_stop` is 1. No `seq_start` occurs while a sequence runs. A periodic start that falls due during a run is held and issued in the cycle after the stop cycle. The period counter restarts at that start.
- R7: With `repeat_mode`=1, `seq_start` is 1 in the cycle after the stop cycle of the running sequence. The divider settings have no effect on this.
- R8: `start_flag` is 1 in every cycle in which `seq_start` is 1. `stop_flag` becomes 1 in the cycle after a stop cycle of a running sequence.
- R9: Each flag stays set until its clear input is 1 at a clock edge. If a clear and a set occur at the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Loads the three divider fields into the shadow settings |
| cfg_div2 | input | D2W | Second-stage divide factor |
| cfg_div3a | input | D3W | Third-stage factor, first field |
| cfg_div3b | input | D3W | Third-stage factor, second field |
| repeat_mode | input | 1 | 0 = periodic starts, 1 = restart right after a stop state |
| seq_stop | input | 1 | Sequencer is in a state flagged as last |
| clr_start | input | 1 | Write-1 clear of start_flag |
| clr_stop | input | 1 | Write-1 clear of stop_flag |
| seq_start | output | 1 | One-cycle pulse: the sequencer enters its first state |
| start_flag | output | 1 | Sticky: a sequence has started |
| stop_flag | output | 1 | Sticky: a sequence reached its stop state |

## Verification
The hardest case to reach is a periodic start that falls due while a sequence is still running. To reach it, the bench's sequencer model is set to run longer than the programmed period. The held start must then follow the stop cycle exactly, and the interval must equal the sequence length rather than the period. The clear-versus-set collision is also forced on purpose. A flag clear is issued in the same cycle as a stop state, and again during one-cycle repeat sequences, so that both flag types meet a set and a clear at the same edge.

// File: rtl/seq_start_pkg.sv
`timescale 1ns/1ps
package seq_start_pkg;
  typedef enum logic {
    START_PERIODIC = 1'b0,
    START_REPEAT   = 1'b1
  } start_mode_e;
endpackage

// File: rtl/seq_period_calc.sv
`timescale 1ns/1ps
// Turns the three divider fields into a counter reload value (period - 1),
// with a product of 0 or 1 clamped to a period of one cycle.
module seq_period_calc #(
  parameter int D2W = 4,
  parameter int D3W = 8,
  localparam int PW = D2W + 2 * D3W
) (
  input  logic [D2W-1:0] div2,
  input  logic [D3W-1:0] div3a,
  input  logic [D3W-1:0] div3b,
  output logic [PW-1:0]  reload
);
  logic [PW-1:0] prod;

  always_comb begin
    prod = PW'(div2) * PW'(div3a) * PW'(div3b);
    if (prod <= PW'(1)) reload = '0;
    else                reload = prod - PW'(1);
  end
endmodule

// File: rtl/seq_period_timer.sv
`timescale 1ns/1ps
// Down-counter that flags a due start. A start that falls due while it
// cannot be taken is remembered until the next start.
module seq_period_timer #(
  parameter int PW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [PW-1:0] load_new,
  input  logic [PW-1:0] load_cur,
  output logic          due
);
  logic [PW-1:0] cnt;
  logic          pend;

  assign due = (cnt == '0) || pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (take) begin
      cnt  <= load_new;
      pend <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= load_cur;
      pend <= 1'b1;
    end else begin
      cnt  <= cnt - PW'(1);
    end
  end

  // A held start survives until a start takes it (R6)
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (pend && !take) |=> due);
endmodule

// File: rtl/seq_sticky_flag.sv
`timescale 1ns/1ps
module seq_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (flag & ~clr) | set;
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
  p_clear_only_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/seq_start_ctrl.sv
`timescale 1ns/1ps
module seq_start_ctrl
  import seq_start_pkg::*;
#(
  parameter int D2W = 4,
  parameter int D3W = 8,
  parameter logic [D2W-1:0] DIV2_RST  = 4'd2,
  parameter logic [D3W-1:0] DIV3A_RST = 8'd9,
  parameter logic [D3W-1:0] DIV3B_RST = 8'd18
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [D2W-1:0] cfg_div2,
  input  logic [D3W-1:0] cfg_div3a,
  input  logic [D3W-1:0] cfg_div3b,
  input  logic           repeat_mode,
  input  logic           seq_stop,
  input  logic           clr_start,
  input  logic           clr_stop,
  output logic           seq_start,
  output logic           start_flag,
  output logic           stop_flag
);
  localparam int PW = D2W + 2 * D3W;

  start_mode_e    mode;
  logic [D2W-1:0] sh_div2,  act_div2;
  logic [D3W-1:0] sh_div3a, act_div3a;
  logic [D3W-1:0] sh_div3b, act_div3b;
  logic [PW-1:0]  reload_new, reload_cur;
  logic           busy_q;
  logic           due;
  logic           idle_next;
  logic           start_d;
  logic           stop_hit;

  assign mode = start_mode_e'(repeat_mode);

  // Shadow settings: written at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_div2  <= DIV2_RST;
      sh_div3a <= DIV3A_RST;
      sh_div3b <= DIV3B_RST;
    end else if (cfg_wr) begin
      sh_div2  <= cfg_div2;
      sh_div3a <= cfg_div3a;
      sh_div3b <= cfg_div3b;
    end
  end

  // Active settings: copied from the shadow at every sequence start
  always_ff @(posedge clk) begin
    if (rst) begin
      act_div2  <= DIV2_RST;
      act_div3a <= DIV3A_RST;
      act_div3b <= DIV3B_RST;
    end else if (start_d) begin
      act_div2  <= sh_div2;
      act_div3a <= sh_div3a;
      act_div3b <= sh_div3b;
    end
  end

  seq_period_calc #(.D2W(D2W), .D3W(D3W)) u_calc_new (
    .div2(sh_div2), .div3a(sh_div3a), .div3b(sh_div3b), .reload(reload_new)
  );

  seq_period_calc #(.D2W(D2W), .D3W(D3W)) u_calc_cur (
    .div2(act_div2), .div3a(act_div3a), .div3b(act_div3b), .reload(reload_cur)
  );

  seq_period_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst(rst), .take(start_d),
    .load_new(reload_new), .load_cur(reload_cur), .due(due)
  );

  // Next cycle is free of a running sequence
  assign idle_next = !busy_q || seq_stop;
  assign stop_hit  = busy_q && seq_stop;
  assign start_d   = idle_next && ((mode == START_REPEAT) || due);

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_start <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      seq_start <= start_d;
      if (start_d)       busy_q <= 1'b1;
      else if (seq_stop) busy_q <= 1'b0;
    end
  end

  seq_sticky_flag u_start_flag (
    .clk(clk), .rst(rst), .set(start_d), .clr(clr_start), .flag(start_flag)
  );

  seq_sticky_flag u_stop_flag (
    .clk(clk), .rst(rst), .set(stop_hit), .clr(clr_stop), .flag(stop_flag)
  );

  // Starts only when no sequence was left running (R6)
  p_one_seq_r6: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> ($past(!busy_q) || $past(seq_stop)));

  // Repeat mode restarts right after the stop cycle (R7)
  p_repeat_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (repeat_mode && busy_q && seq_stop) |=> seq_start);

  p_start_flag_r8: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> start_flag);

  p_stop_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && seq_stop) |=> stop_flag);
endmodule

// File: tb/seq_start_ctrl_test.sv
`timescale 1ns/1ps
module seq_start_ctrl_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_wr;
  logic [3:0] cfg_div2;
  logic [7:0] cfg_div3a;
  logic [7:0] cfg_div3b;
  logic       repeat_mode;
  logic       seq_stop;
  logic       clr_start;
  logic       clr_stop;
  logic       seq_start;
  logic       start_flag;
  logic       stop_flag;

  int errors = 0;
  int checks = 0;
  int auto_len = 1;
  int rem = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seq_start_ctrl uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_div2(cfg_div2),
    .cfg_div3a(cfg_div3a), .cfg_div3b(cfg_div3b), .repeat_mode(repeat_mode),
    .seq_stop(seq_stop), .clr_start(clr_start), .clr_stop(clr_stop),
    .seq_start(seq_start), .start_flag(start_flag), .stop_flag(stop_flag)
  );

  // Sequencer model: a run of auto_len states, the last one flagged as stop
  initial begin
    seq_stop = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      if (rst) begin
        rem = 0;
        seq_stop = 1'b0;
      end else begin
        if (seq_start) rem = auto_len;
        seq_stop = (rem == 1);
        if (rem > 0) rem--;
      end
    end
  end

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_start(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!seq_start && n < 3000);
  endtask

  task automatic cfg_write(input int d2, input int a, input int b);
    cfg_div2  = 4'(d2);
    cfg_div3a = 8'(a);
    cfg_div3b = 8'(b);
    cfg_wr    = 1'b1;
    tick();
    cfg_wr    = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) tick();
    check("R1 seq_start in reset", seq_start, 0);
    check("R1 start_flag in reset", start_flag, 0);
    check("R1 stop_flag in reset", stop_flag, 0);
    rst = 1'b0;
    tick();
    check("R2 first start after reset", seq_start, 1);
    check("R2 start_flag with first start", start_flag, 1);
  endtask

  task automatic t_holdback;
    int n;
    cfg_write(2, 3, 1);
    wait_start(n);
    check("R4 old default period kept (324-1 after write)", n, 323);
    wait_start(n);
    check("R3 period 2*3*1", n, 6);
    wait_start(n);
    check("R3 period 2*3*1 again", n, 6);
  endtask

  task automatic t_flags;
    int n;
    clr_start = 1'b1;
    clr_stop  = 1'b1;
    tick();
    clr_start = 1'b0;
    clr_stop  = 1'b0;
    check("R9 start_flag cleared", start_flag, 0);
    check("R9 stop_flag set wins over clear", stop_flag, 1);
    clr_stop = 1'b1;
    tick();
    clr_stop = 1'b0;
    check("R9 stop_flag cleared", stop_flag, 0);
    wait_start(n);
    check("R8 start_flag at start", start_flag, 1);
  endtask

  task automatic t_product;
    int n;
    cfg_write(3, 2, 2);
    wait_start(n);
    check("R4 old period 6 kept", n, 5);
    wait_start(n);
    check("R3 period 3*2*2", n, 12);
  endtask

  task automatic t_overlap;
    int n;
    auto_len = 20;
    wait_start(n);
    check("R6 held start after long run", n, 20);
    wait_start(n);
    check("R6 held start after long run again", n, 20);
    auto_len = 1;
  endtask

  task automatic t_clamp;
    int n;
    cfg_write(2, 0, 5);
    wait_start(n);
    wait_start(n);
    check("R5 product 0 gives period 1", n, 1);
    wait_start(n);
    check("R5 product 0 gives period 1 again", n, 1);
    cfg_write(1, 1, 1);
    wait_start(n);
    wait_start(n);
    check("R5 product 1 gives period 1", n, 1);
  endtask

  task automatic t_repeat;
    int n;
    cfg_write(15, 255, 255);
    wait_start(n);
    repeat_mode = 1'b1;
    auto_len    = 4;
    wait_start(n);
    check("R7 repeat restart after 4-state run", n, 4);
    wait_start(n);
    check("R7 repeat restart after 4-state run again", n, 4);
    auto_len = 1;
    wait_start(n);
    wait_start(n);
    check("R7 repeat restart after 1-state run", n, 1);
    clr_start = 1'b1;
    tick();
    clr_start = 1'b0;
    check("R9 start_flag set wins in repeat", start_flag, 1);
    check("R7 start continues every cycle", seq_start, 1);
  endtask

  initial begin
    cfg_wr = 1'b0;
    cfg_div2 = '0;
    cfg_div3a = '0;
    cfg_div3b = '0;
    repeat_mode = 1'b0;
    clr_start = 1'b0;
    clr_stop = 1'b0;
    rst = 1'b1;
    #1;
    t_reset();
    t_holdback();
    t_flags();
    t_product();
    t_overlap();
    t_clamp();
    t_repeat();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule